// File: doc/BRIEF.md
# SPI FIFO DMA Address Engine

This block is the sequencer that carries bytes between system memory and the SPI data FIFO when a transfer is too long for the 8-entry FIFO to be served by software. Software programs a start address and an exclusive end address, picks a direction and a pass mode, then raises the enable bit. From that point the engine walks a current-address pointer one byte at a time until it reaches the end address. In the transmit direction it reads each byte from memory and pushes it into the FIFO. In the receive direction it pops each byte from the FIFO and writes it to memory.

The memory side is a valid/ready request channel with one request in flight. A read's data comes back on a separate valid strobe that the engine always accepts. The FIFO side is two valid/ready streams: the engine drives push data into the FIFO and takes pop data from it. On each channel, once the engine raises valid it keeps valid and payload steady until ready is seen. On the pop stream the engine raises ready only while it has room for a byte. Configuration, the live pointer, the busy level and the sticky end flag are plain levels.

In single-pass mode the engine stops at the end address. In loop mode it reloads the start address and carries on, raising the end flag at every wrap, until software drops the enable bit.

Top module: `spi_fifo_dma`

## Requirements
- R1: After reset, busy, dma_end_flag, mem_req_valid, fifo_push_valid and fifo_pop_ready are 0, and cur_addr is 0.
- R2: The engine arms on a clock edge where cfg_enable is 1, it was 0 at the previous edge, and the engine is idle. On that edge it captures start, end, direction and loop mode, loads cur_addr with the start address, clears dma_end_flag and raises busy. Configuration changes made after that edge have no effect on the running job.
- R3: With cfg_dir_in = 0 (transmit), the engine handles each byte the same way. It issues a read (mem_req_write = 0) at cur_addr, takes the byte returned with mem_rd_valid, and presents that byte on the FIFO push stream. Bytes reach the FIFO in increasing address order.
- R4: With cfg_dir_in = 1 (receive), each byte accepted on the FIFO pop stream is written to memory (mem_req_write = 1) at cur_addr, in arrival order.
- R5: Once mem_req_valid or fifo_push_valid is high without its ready, that valid stays high with a stable payload. At most one of mem_req_valid, fifo_push_valid and fifo_pop_ready is high at a time. In transmit, no new read is issued until the previous byte has been pushed.
- R6: cur_addr changes only when a byte completes, and then advances by one. The end address is exclusive, so the last byte addressed is end - 1.
- R7: In single-pass mode (cfg_loop = 0), completing byte end - 1 leaves cur_addr = end, drops busy and sets dma_end_flag. The flag stays set while cfg_enable is low. No request follows, even while cfg_enable stays high.
- R8: In loop mode (cfg_loop = 1), completing byte end - 1 sets dma_end_flag, reloads cur_addr with the start address and continues.
- R9: If cfg_enable is low when a byte completes, the engine goes idle after that byte and issues no further request.
- R10: When the start address equals the end address at arming, dma_end_flag is set at once, busy stays low and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | DMA enable; a 0-to-1 change while idle starts a job |
| cfg_loop | input | 1 | 1 = reload start at end, 0 = single pass |
| cfg_dir_in | input | 1 | 0 = memory to FIFO, 1 = FIFO to memory |
| cfg_start_addr | input | 32 | First byte address |
| cfg_end_addr | input | 32 | Address one past the last byte |
| cur_addr | output | 32 | Live current-address pointer |
| busy | output | 1 | Job in progress |
| dma_end_flag | output | 1 | Sticky end-address-reached flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 8 | Read data |
| fifo_push_valid | output | 1 | Byte offered to the FIFO |
| fifo_push_ready | input | 1 | FIFO has space |
| fifo_push_data | output | 8 | Byte for the FIFO |
| fifo_pop_valid | input | 1 | FIFO not empty |
| fifo_pop_ready | output | 1 | Engine takes the FIFO byte |
| fifo_pop_data | input | 8 | Byte from the FIFO |

## Verification
Transmit jobs run with memory bytes computed from their address. This separates an address or ordering fault from a data-path fault, because a wrong address shows up as a wrong byte at the push stream. Receive jobs cross a 4 KB boundary with irregular FIFO arrivals, which checks the carry in the pointer and the pairing of popped bytes with write addresses. A short loop job cut off by dropping the enable tells the wrap reload apart from a plain increment and shows the in-flight byte finishing. An empty job and a job whose configuration changes mid-run show the arming capture. Heavy back-pressure on every ready input exercises the hold rules and the single-outstanding read.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_WAIT    = 2'd2,
    ST_DELIVER = 2'd3
  } dma_state_e;

  localparam logic DIR_TX = 1'b0;
  localparam logic DIR_RX = 1'b1;
endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] start_in,
  input  logic [AW-1:0] end_in,
  input  logic          step,
  input  logic          loop_q,
  output logic [AW-1:0] cur,
  output logic          at_last
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] start_q, end_q, cur_q, cur_inc;

  assign cur_inc = cur_q + ONE;
  assign at_last = (cur_inc == end_q);
  assign cur     = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      cur_q   <= '0;
    end else if (arm) begin
      start_q <= start_in;
      end_q   <= end_in;
      cur_q   <= start_in;
    end else if (step) begin
      if (at_last && loop_q) cur_q <= start_q;
      else                   cur_q <= cur_inc;
    end
  end
endmodule

// File: rtl/dma_byte_hold.sv
module dma_byte_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import spi_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_enable,
  input  logic cfg_loop,
  input  logic cfg_dir_in,
  input  logic empty_job,
  input  logic at_last,
  input  logic mem_req_ready,
  input  logic mem_rd_valid,
  input  logic fifo_push_ready,
  input  logic fifo_pop_valid,
  output logic arm,
  output logic step,
  output logic capture,
  output logic dir_q,
  output logic loop_q,
  output logic busy,
  output logic end_flag,
  output logic req_valid,
  output logic push_valid,
  output logic pop_ready
);
  dma_state_e state;
  logic       en_q;
  logic       deliver_hs;

  assign busy       = (state != ST_IDLE);
  assign arm        = cfg_enable && !en_q && !busy;

  assign req_valid  = ((state == ST_FETCH)   && (dir_q == DIR_TX)) ||
                      ((state == ST_DELIVER) && (dir_q == DIR_RX));
  assign push_valid = (state == ST_DELIVER) && (dir_q == DIR_TX);
  assign pop_ready  = (state == ST_FETCH)   && (dir_q == DIR_RX);

  assign deliver_hs = (dir_q == DIR_TX) ? fifo_push_ready : mem_req_ready;
  assign step       = (state == ST_DELIVER) && deliver_hs;
  assign capture    = ((state == ST_WAIT) && mem_rd_valid) ||
                      (pop_ready && fifo_pop_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      en_q     <= 1'b0;
      dir_q    <= DIR_TX;
      loop_q   <= 1'b0;
      end_flag <= 1'b0;
    end else begin
      en_q <= cfg_enable;
      if (arm) begin
        dir_q    <= cfg_dir_in;
        loop_q   <= cfg_loop;
        end_flag <= empty_job;
        state    <= empty_job ? ST_IDLE : ST_FETCH;
      end else begin
        case (state)
          ST_FETCH: begin
            if (dir_q == DIR_TX) begin
              if (mem_req_ready) state <= ST_WAIT;
            end else if (fifo_pop_valid) begin
              state <= ST_DELIVER;
            end
          end
          ST_WAIT: begin
            if (mem_rd_valid) state <= ST_DELIVER;
          end
          ST_DELIVER: begin
            if (deliver_hs) begin
              if (at_last) end_flag <= 1'b1;
              if ((at_last && !loop_q) || !cfg_enable) state <= ST_IDLE;
              else                                      state <= ST_FETCH;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_fifo_dma.sv
module spi_fifo_dma #(
  parameter int AW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_loop,
  input  logic          cfg_dir_in,
  input  logic [AW-1:0] cfg_start_addr,
  input  logic [AW-1:0] cfg_end_addr,
  output logic [AW-1:0] cur_addr,
  output logic          busy,
  output logic          dma_end_flag,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  output logic          fifo_push_valid,
  input  logic          fifo_push_ready,
  output logic [DW-1:0] fifo_push_data,
  input  logic          fifo_pop_valid,
  output logic          fifo_pop_ready,
  input  logic [DW-1:0] fifo_pop_data
);
  logic          arm, step, capture, dir_q, loop_q, at_last, empty_job;
  logic [DW-1:0] cap_data, byte_q;

  assign empty_job = (cfg_start_addr == cfg_end_addr);
  assign cap_data  = dir_q ? fifo_pop_data : mem_rd_data;

  dma_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_enable      (cfg_enable),
    .cfg_loop        (cfg_loop),
    .cfg_dir_in      (cfg_dir_in),
    .empty_job       (empty_job),
    .at_last         (at_last),
    .mem_req_ready   (mem_req_ready),
    .mem_rd_valid    (mem_rd_valid),
    .fifo_push_ready (fifo_push_ready),
    .fifo_pop_valid  (fifo_pop_valid),
    .arm             (arm),
    .step            (step),
    .capture         (capture),
    .dir_q           (dir_q),
    .loop_q          (loop_q),
    .busy            (busy),
    .end_flag        (dma_end_flag),
    .req_valid       (mem_req_valid),
    .push_valid      (fifo_push_valid),
    .pop_ready       (fifo_pop_ready)
  );

  dma_addr_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .start_in (cfg_start_addr),
    .end_in   (cfg_end_addr),
    .step     (step),
    .loop_q   (loop_q),
    .cur      (cur_addr),
    .at_last  (at_last)
  );

  dma_byte_hold #(.DW(DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (capture),
    .din   (cap_data),
    .dout  (byte_q)
  );

  assign mem_req_addr   = cur_addr;
  assign mem_req_write  = dir_q;
  assign mem_req_wdata  = byte_q;
  assign fifo_push_data = byte_q;
endmodule

// File: rtl/spi_fifo_dma_chk.sv
module spi_fifo_dma_chk #(
  parameter int AW = 32,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_enable,
  input logic [AW-1:0] cur_addr,
  input logic          busy,
  input logic          dma_end_flag,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          fifo_push_valid,
  input logic          fifo_push_ready,
  input logic [DW-1:0] fifo_push_data,
  input logic          fifo_pop_ready
);
  logic byte_done;
  assign byte_done = (fifo_push_valid && fifo_push_ready) ||
                     (mem_req_valid && mem_req_ready && mem_req_write);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  p_push_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push_valid && !fifo_push_ready |=> fifo_push_valid && $stable(fifo_push_data));

  p_one_channel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, fifo_push_valid, fifo_pop_ready}));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !byte_done |=> $stable(cur_addr));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_req_valid || fifo_push_valid || fifo_pop_ready));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_end_flag && !cfg_enable |=> dma_end_flag);
endmodule

bind spi_fifo_dma spi_fifo_dma_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_spi_fifo_dma.sv
`timescale 1ns/1ps
module tb_spi_fifo_dma;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_loop = 1'b0, cfg_dir_in = 1'b0;
  logic [31:0] cfg_start_addr = '0, cfg_end_addr = '0;
  logic [31:0] cur_addr, mem_req_addr;
  logic        busy, dma_end_flag, mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0, mem_rd_valid = 1'b0;
  logic [7:0]  mem_req_wdata, mem_rd_data = '0, fifo_push_data, fifo_pop_data = '0;
  logic        fifo_push_valid, fifo_push_ready = 1'b0;
  logic        fifo_pop_valid = 1'b0, fifo_pop_ready;

  int checks = 0, fails = 0;
  int rdy_pct = 70;
  int req_count = 0;
  int order_err = 0;
  logic        exp_dir = 1'b0;
  logic        rd_pend = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [31:0] exp_addr_q[$];
  logic [7:0]  data_q[$];
  logic [7:0]  rx_src_q[$];

  spi_fifo_dma dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory / FIFO models and scoreboard monitor
  always @(negedge clk) begin
    mem_req_ready   = ($urandom % 100) < rdy_pct;
    fifo_push_ready = ($urandom % 100) < rdy_pct;
    mem_rd_valid    = rd_pend;
    mem_rd_data     = rd_pend ? mem_byte(rd_addr) : 8'h00;
    rd_pend         = 1'b0;
    fifo_pop_valid  = (rx_src_q.size() > 0) && (($urandom % 100) < rdy_pct);
    fifo_pop_data   = fifo_pop_valid ? rx_src_q[0] : 8'h00;
    #1;
    if (rst_n && !busy && (mem_req_valid || fifo_push_valid || fifo_pop_ready))
      order_err++;
    if (mem_req_valid && mem_req_ready) begin
      req_count++;
      check(mem_req_write == exp_dir, "R3/R4 direction", 32'(mem_req_write), 32'(exp_dir));
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R7/R9 unexpected request", mem_req_addr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea;
        ea = exp_addr_q.pop_front();
        check(mem_req_addr == ea, "R6/R8 address", mem_req_addr, ea);
      end
      if (!mem_req_write) begin
        if (data_q.size() != 0) order_err++;
        rd_pend = 1'b1;
        rd_addr = mem_req_addr;
        data_q.push_back(mem_byte(mem_req_addr));
      end else if (data_q.size() == 0) begin
        check(1'b0, "R4 write without pop", 32'(mem_req_wdata), 32'h0);
      end else begin
        logic [7:0] ed;
        ed = data_q.pop_front();
        check(mem_req_wdata == ed, "R4 write data", 32'(mem_req_wdata), 32'(ed));
      end
    end
    if (fifo_push_valid && fifo_push_ready) begin
      if (data_q.size() == 0) begin
        check(1'b0, "R3 push without read", 32'(fifo_push_data), 32'h0);
      end else begin
        logic [7:0] ed;
        ed = data_q.pop_front();
        check(fifo_push_data == ed, "R3 push data", 32'(fifo_push_data), 32'(ed));
      end
    end
    if (fifo_pop_valid && fifo_pop_ready)
      data_q.push_back(rx_src_q.pop_front());
  end

  // driver: queue expected addresses then arm the engine
  task automatic start_job(logic [31:0] s, logic [31:0] e, logic dir, logic lp, int n);
    logic [31:0] a;
    a = s;
    for (int i = 0; i < n; i++) begin
      exp_addr_q.push_back(a);
      a = (a + 1 == e) ? s : a + 1;
    end
    exp_dir = dir;
    @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk);
    cfg_start_addr = s; cfg_end_addr = e; cfg_dir_in = dir; cfg_loop = lp;
    cfg_enable = 1'b1;
    @(negedge clk); #2;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk); #2;
      n++;
    end
  endtask

  task automatic fill_rx(int n, logic [7:0] seed);
    for (int i = 0; i < n; i++) rx_src_q.push_back(seed + 8'(i * 7));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    check(!busy && !dma_end_flag, "R1 busy/flag", {busy, dma_end_flag}, 0);
    check(!mem_req_valid && !fifo_push_valid && !fifo_pop_ready, "R1 valids",
          {mem_req_valid, fifo_push_valid, fifo_pop_ready}, 0);
    check(cur_addr == 0, "R1 cur_addr", cur_addr, 0);

    // transmit, single pass, 20 bytes (R2 R3 R6 R7)
    start_job(32'h2000_0010, 32'h2000_0024, 1'b0, 1'b0, 20);
    check(cur_addr == 32'h2000_0010, "R2 load start", cur_addr, 32'h2000_0010);
    check(busy && !dma_end_flag, "R2 busy on arm", {busy, dma_end_flag}, 2);
    wait_idle();
    check(dma_end_flag, "R7 flag set", 32'(dma_end_flag), 1);
    check(cur_addr == 32'h2000_0024, "R7 cur at end", cur_addr, 32'h2000_0024);
    check(exp_addr_q.size() == 0 && data_q.size() == 0, "R3 all bytes moved",
          exp_addr_q.size() + data_q.size(), 0);
    base = req_count;
    repeat (20) @(negedge clk);
    #2;
    check(req_count == base && !busy, "R7 no request while enable high", req_count, base);

    // receive, single pass across a 4 KB boundary (R4 R6 R2 flag clear)
    fill_rx(12, 8'h31);
    start_job(32'h8000_0FFA, 32'h8000_1006, 1'b1, 1'b0, 12);
    check(!dma_end_flag, "R2 flag cleared on arm", 32'(dma_end_flag), 0);
    wait_idle();
    check(rx_src_q.size() == 0 && data_q.size() == 0 && exp_addr_q.size() == 0,
          "R4 all bytes written", rx_src_q.size() + data_q.size(), 0);
    check(cur_addr == 32'h8000_1006 && dma_end_flag, "R7 receive end", cur_addr, 32'h8000_1006);

    // empty job (R10)
    base = req_count;
    start_job(32'h0000_0040, 32'h0000_0040, 1'b0, 1'b0, 0);
    check(dma_end_flag && !busy, "R10 flag without busy", {busy, dma_end_flag}, 1);
    check(cur_addr == 32'h40, "R10 cur_addr", cur_addr, 32'h40);
    repeat (10) @(negedge clk);
    #2;
    check(req_count == base, "R10 no request", req_count, base);

    // configuration changed mid-job is ignored (R2)
    start_job(32'h0000_0300, 32'h0000_030A, 1'b0, 1'b0, 10);
    repeat (4) @(negedge clk);
    cfg_start_addr = 32'h0000_0900; cfg_end_addr = 32'h0000_0901;
    cfg_dir_in = 1'b1; cfg_loop = 1'b1;
    wait_idle();
    check(cur_addr == 32'h0000_030A && exp_addr_q.size() == 0, "R2 config captured",
          cur_addr, 32'h0000_030A);

    // loop mode, stopped by dropping enable (R8 R9)
    base = req_count;
    start_job(32'h0000_0500, 32'h0000_0503, 1'b0, 1'b1, 40);
    while (req_count < base + 8) begin
      @(negedge clk); #2;
    end
    check(dma_end_flag && busy, "R8 flag set and still running", {busy, dma_end_flag}, 3);
    cfg_enable = 1'b0;
    base = req_count;
    wait_idle();
    repeat (5) @(negedge clk);
    #2;
    check(!busy && (req_count - base) <= 1, "R9 stop after in-flight byte", req_count - base, 1);
    check(data_q.size() == 0, "R9 in-flight byte delivered", data_q.size(), 0);
    check(cur_addr >= 32'h500 && cur_addr < 32'h503, "R8 pointer within window", cur_addr, 32'h500);
    exp_addr_q.delete();

    // heavy back-pressure both directions (R5)
    rdy_pct = 20;
    start_job(32'h0000_0600, 32'h0000_060C, 1'b0, 1'b0, 12);
    wait_idle();
    fill_rx(9, 8'hC0);
    start_job(32'h0000_0700, 32'h0000_0709, 1'b1, 1'b0, 9);
    wait_idle();
    check(exp_addr_q.size() == 0 && data_q.size() == 0 && rx_src_q.size() == 0,
          "R5 back-pressure jobs complete", exp_addr_q.size(), 0);
    check(order_err == 0, "R5 single outstanding / R7 idle quiet", order_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule